// File: doc/BRIEF.md
# Masked-Write Latched Status Register

This block is an 8-bit status register for a controller that a host services by polling or by interrupt. Each bit position is configured as either latched or real-time. A latched bit captures the rising edge of an event input that arrives asynchronously to the host. It holds that capture until the host collects it. A real-time bit simply shows the present, synchronized level of its input.

The host collects latched bits with a write-then-read handshake. It first writes a select byte to the status address. For every latched position written as one, the current latch value is copied into a host-visible snapshot and the latch is cleared. Positions written as zero keep their earlier snapshot and their latch. A following read returns the snapshot for latched positions and live levels for real-time positions.

A separate interrupt mask register chooses which pending latched events pull the active-low interrupt output low. If a new event lands in the same cycle as a clear of its bit, the event is kept. A second masked write therefore never loses an event.

Top module: `stat_latch_reg`

## Requirements
- R1: After reset, the mask register reads 0, every latch and snapshot bit is 0, `bus_rdata` is 0 and `irq_n` is 1.
- R2: A latched bit is set once for each rising edge of its event input, after two synchronizer stages. It stays set after the input falls. It is not set again while the input stays high, even if it is cleared in the meantime.
- R3: A write to address 0 copies the current latch value of each latched position whose `bus_wdata` bit is 1 into that position's snapshot, and clears that latch.
- R4: For latched positions whose `bus_wdata` bit is 0 in a write to address 0, the snapshot keeps its previous value and the latch is not cleared.
- R5: Real-time positions (0 in `LATCH_MAP`; by default bits 7:4) read the synchronized level of their event input. They keep no history and are unaffected by writes.
- R6: Address 1 is the interrupt mask register. It is readable and writable, and its bit i enables latched bit i onto the interrupt. By default, latched bits are 3:0.
- R7: `irq_n` is 0 exactly when some latched bit is set and its mask bit is 1. It follows the latch and mask state with one register stage of delay.
- R8: When an event edge and a clear of the same bit occur in the same clock cycle, the latch stays set. The snapshot takes the value the latch held before that cycle.
- R9: `bus_rdata` is loaded on the clock edge where `bus_rd` is 1, with the status view at address 0, the mask at address 1, and 0 at other addresses. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (0 status, 1 interrupt mask) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data / select byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| evt_in | input | 8 | Asynchronous event and condition inputs |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Several properties are checked on every cycle: an event edge always leaves its latch set (R8), a clear without an event empties the latch, unselected snapshot bits never change, an edge pulse lasts one cycle, `irq_n` falls only when an unmasked latch was pending, and read data holds between read strobes. The bench must show the rest with scenarios. These include the arithmetic relation between mask and pending patterns in all 256 combinations, snapshot contents after selective writes, live reporting of real-time inputs, the rule that one edge sets a latch once, and the exact cycle of an event that collides with a clear.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int unsigned SLR_ADDR_W = 2;
  localparam logic [SLR_ADDR_W-1:0] SLR_STAT_ADDR = 2'd0;
  localparam logic [SLR_ADDR_W-1:0] SLR_MASK_ADDR = 2'd1;
endpackage

// File: rtl/slr_sync_edge.sv
module slr_sync_edge #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else     stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= '0;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg_q[STAGES-1];
  end

  assign level_o = stg_q[STAGES-1];
  assign rise_o  = stg_q[STAGES-1] & ~prev_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/slr_latch_bank.sv
module slr_latch_bank #(
  parameter int unsigned W         = 8,
  parameter logic [W-1:0] LATCH_MAP = 8'h0F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] set_w, latch_q, latch_d, snap_q, snap_d;

  always_comb begin
    set_w   = rise_i & LATCH_MAP;
    // a new event overrides a simultaneous clear
    latch_d = (set_w | (latch_q & ~clr_i)) & LATCH_MAP;
    snap_d  = ((clr_i & latch_q) | (~clr_i & snap_q)) & LATCH_MAP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      snap_q  <= '0;
    end else begin
      latch_q <= latch_d;
      snap_q  <= snap_d;
    end
  end

  assign latch_o = latch_q;
  assign snap_o  = snap_q;

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_w != '0) |=> ((latch_q & $past(set_w)) == $past(set_w)));
  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_w) != '0) |=> ((latch_q & $past(clr_i & ~set_w)) == '0));
  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i != {W{1'b1}}) |=> (((snap_q ^ $past(snap_q)) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/slr_irq_gen.sv
module slr_irq_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic [W-1:0] latch_i,
  output logic [W-1:0] mask_o,
  output logic         irq_n_o
);
  logic [W-1:0] mask_q;
  logic         irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      irq_n_q <= ~|(latch_i & mask_q);
    end
  end

  assign mask_o  = mask_q;
  assign irq_n_o = irq_n_q;

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n_q) |-> $past(|(latch_i & mask_q)));
endmodule

// File: rtl/stat_latch_reg.sv
module stat_latch_reg
  import slr_pkg::*;
#(
  parameter int unsigned  W           = 8,
  parameter int unsigned  SYNC_STAGES = 2,
  parameter logic [W-1:0] LATCH_MAP   = 8'h0F
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SLR_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [W-1:0]          bus_wdata,
  input  logic                  bus_rd,
  output logic [W-1:0]          bus_rdata,
  input  logic [W-1:0]          evt_in,
  output logic                  irq_n
);
  logic [W-1:0] level_w, rise_w, clr_w, latch_w, snap_w, mask_w, view_w;
  logic [W-1:0] rd_mux, rdata_q;
  logic         stat_we, mask_we;

  assign stat_we = bus_wr && (bus_addr == SLR_STAT_ADDR);
  assign mask_we = bus_wr && (bus_addr == SLR_MASK_ADDR);
  assign clr_w   = stat_we ? bus_wdata : '0;

  slr_sync_edge #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(evt_in),
    .level_o(level_w), .rise_o(rise_w)
  );

  slr_latch_bank #(.W(W), .LATCH_MAP(LATCH_MAP)) u_bank (
    .clk(clk), .rst(rst), .rise_i(rise_w), .clr_i(clr_w),
    .latch_o(latch_w), .snap_o(snap_w)
  );

  slr_irq_gen #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .mask_we_i(mask_we), .mask_wdata_i(bus_wdata),
    .latch_i(latch_w), .mask_o(mask_w), .irq_n_o(irq_n)
  );

  assign view_w = (snap_w & LATCH_MAP) | (level_w & ~LATCH_MAP);

  always_comb begin
    case (bus_addr)
      SLR_STAT_ADDR: rd_mux = view_w;
      SLR_MASK_ADDR: rd_mux = mask_w;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_stat_latch_reg.sv
`timescale 1ns/1ps
module tb_stat_latch_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] evt_in = '0;
  logic       irq_n;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  stat_latch_reg dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d, held;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    chk("R1 rdata", bus_rdata, 0);
    bus_read(2'd0, d); chk("R1 status", d, 0);
    bus_read(2'd1, d); chk("R1 mask", d, 0);

    // R6 mask register read/write, unused address
    bus_write(2'd1, 8'hA5); bus_read(2'd1, d); chk("R6 mask rw", d, 8'hA5);
    bus_write(2'd1, 8'h3C); bus_read(2'd1, d); chk("R6 mask rw", d, 8'h3C);
    bus_read(2'd2, d); chk("R9 unused addr", d, 0);

    // R7/R3 sweep: every mask against every pending pattern
    for (int m = 0; m < 16; m++) begin
      bus_write(2'd1, 8'(m));
      for (int p = 0; p < 16; p++) begin
        evt_in[3:0] = 4'(p); idle(5);
        evt_in[3:0] = 4'h0;  idle(4);
        chk("R7 irq sweep", irq_n, ((m & p) != 0) ? 0 : 1);
        bus_write(2'd0, 8'h0F); idle(2);
        chk("R7 irq release", irq_n, 1);
        bus_read(2'd0, d);
        chk("R3 snapshot", d, 32'(p));
      end
    end
    bus_write(2'd0, 8'h0F);
    bus_read(2'd0, d); chk("R3 cleared latch", d, 0);

    // R4 selective collection
    bus_write(2'd1, 8'h02);
    evt_in[1:0] = 2'b11; idle(5); evt_in[1:0] = 2'b00; idle(3);
    chk("R7 pending", irq_n, 0);
    bus_write(2'd0, 8'h01);
    bus_read(2'd0, d); chk("R4 partial", d, 8'h01);
    idle(2); chk("R4 latch kept irq", irq_n, 0);
    bus_write(2'd0, 8'h02);
    bus_read(2'd0, d); chk("R4 hold bit0", d, 8'h03);
    idle(2); chk("R7 irq after collect", irq_n, 1);

    // R2 level held high sets only once
    evt_in[2] = 1'b1; idle(6);
    bus_write(2'd0, 8'h04);
    bus_read(2'd0, d); chk("R2 first edge", d, 8'h07);
    idle(6);
    bus_write(2'd0, 8'h04);
    bus_read(2'd0, d); chk("R2 no reset while high", d, 8'h03);
    evt_in[2] = 1'b0; idle(4);
    bus_write(2'd0, 8'h0F);

    // R5 real-time bits follow level, ignore writes, keep no history
    for (int v = 0; v < 16; v++) begin
      evt_in[7:4] = 4'(v); idle(3);
      bus_read(2'd0, d); chk("R5 live", d, 32'(v << 4));
      bus_write(2'd0, 8'hF0);
      bus_read(2'd0, d); chk("R5 write ignored", d, 32'(v << 4));
    end
    evt_in[7:4] = 4'h0; idle(3);
    bus_read(2'd0, d); chk("R5 no history", d, 0);

    // R8 event in the same cycle as a clear
    bus_write(2'd1, 8'h01);
    evt_in[0] = 1'b1;
    @(negedge clk);
    bus_write(2'd0, 8'h01);
    bus_read(2'd0, d); chk("R8 snapshot pre-value", d, 0);
    idle(2); chk("R8 event kept irq", irq_n, 0);
    bus_write(2'd0, 8'h01);
    bus_read(2'd0, d); chk("R8 event kept", d, 8'h01);
    idle(2); chk("R8 irq released", irq_n, 1);
    evt_in[0] = 1'b0;

    // R9 read data holds without a read strobe
    bus_read(2'd0, held);
    evt_in[7:4] = 4'hF; idle(5);
    chk("R9 hold", bus_rdata, held);
    bus_read(2'd0, d); chk("R9 update", d, {4'hF, held[3:0]});
    evt_in = '0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule